// File: doc/BRIEF.md
# Buffered-Program Command Sequencer for a Parallel NOR Flash Port

This block decodes the host write cycles on a word-wide NOR flash bus and runs the buffered-program command. A command opens with two unlock writes. Next comes a buffer-load opcode written inside the target sector. The following write gives a word count, and then the address/data pairs that fill the staging buffer. A closing confirm write ends the sequence.

Every load write is checked against the sector named by the opcode and against a single aligned buffer line. Any violation sends the block into a sticky abort state. In that state it stays busy with its abort flag raised until the host issues the abort-reset sequence. A correct sequence ends with a one-cycle start pulse. The pulse carries the line address, the first word offset and the count. The captured words can be read from the staging buffer through a registered read port.

The block sits between the host bus decoder and the program engine. It has a synchronous active-high reset, and all of its outputs are registered.

Top module: `nor_wbuf_seq`

## Requirements
- R1: A command is recognised only after the unlock prefix: data 00AAh at a write whose low 12 address bits are 555h, then data 0055h at low address 2AAh. Opcode 0025h written without this prefix leaves busy low.
- R2: If either unlock write carries an unexpected value, the decoder returns to idle with busy and abort_flag both low.
- R3: Opcode 0025h after the prefix records the sector (address bits 15:12) and raises busy from the clock edge that samples it.
- R4: The next write gives the word count minus one, so 0 means one word and 00FFh means a full 256-word line. A count of 0100h or more raises abort_flag.
- R5: Each load write stores its data at buffer index A7..A0. rd_word shows entry rd_idx one clock after rd_idx is sampled.
- R6: A count, load or confirm write whose sector bits differ from the recorded sector raises abort_flag.
- R7: The first load write sets the line (address bits 15:8). Abort_flag rises if the first offset plus the count passes index 255, or if a later load write falls in a different line.
- R8: After the last data word, 0029h at the sector gives go_pulse for exactly one cycle, with go_line, go_first and go_count, and busy drops. Any other confirm value raises abort_flag.
- R9: Once abort_flag is set, it and busy stay high and every other write is ignored. Only 00AAh@555h, then 0055h@2AAh, then 00F0h clears both. A wrong step in that sequence keeps the abort state.
- R10: While rst is high, bus writes are ignored. After reset, busy, abort_flag and go_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 16 | Host word address |
| bus_data | input | 16 | Host write data |
| busy | output | 1 | Sequence in progress or aborted |
| abort_flag | output | 1 | Sticky abort indication |
| go_pulse | output | 1 | One-cycle program start |
| go_line | output | 8 | Line address (address bits 15:8) of the program |
| go_first | output | 8 | First word offset inside the line |
| go_count | output | 8 | Word count minus one |
| rd_idx | input | 8 | Staging buffer read index |
| rd_word | output | 16 | Staging buffer word, one cycle latency |

## Verification
The bench targets the edges of the load window. It uses a count of exactly 00FFh and the first count that is too large, 0100h. It also starts a load at offset FEh so the span carries out of the line. A design with an off-by-one in the span or count test would either abort a legal full-line load or start a program that wraps into the next line.

The bench then checks that the abort state is sticky. It sends writes that a design leaking out of abort would accept, plus a broken abort-reset sequence. It also sends unlock writes while reset is held; a design that honoured them would raise busy on a bare opcode.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UN1, S_UN2, S_CNT, S_LD0, S_LDN, S_CONF, S_AB, S_AB1, S_AB2
  } nwb_st_e;

  localparam logic [7:0]  OP_KEY1  = 8'hAA;
  localparam logic [7:0]  OP_KEY2  = 8'h55;
  localparam logic [7:0]  OP_LOAD  = 8'h25;
  localparam logic [7:0]  OP_CONF  = 8'h29;
  localparam logic [7:0]  OP_CLEAR = 8'hF0;
  localparam logic [11:0] AD_KEY1  = 12'h555;
  localparam logic [11:0] AD_KEY2  = 12'h2AA;
endpackage

// File: rtl/nwb_guard.sv
module nwb_guard #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  parameter int LINE_W   = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          data,
  input  logic [ADDR_W-SECT_LSB-1:0] sect_q,
  input  logic [ADDR_W-LINE_W-1:0]   line_q,
  input  logic [LINE_W-1:0]          cnt_q,
  output logic                       sec_ok,
  output logic                       line_ok,
  output logic                       span_ok,
  output logic                       cnt_ok
);
  logic [LINE_W:0] span_sum;

  assign sec_ok   = addr[ADDR_W-1:SECT_LSB] == sect_q;
  assign line_ok  = addr[ADDR_W-1:LINE_W] == line_q;
  // carry out of the offset field means the load would leave the line
  assign span_sum = {1'b0, addr[LINE_W-1:0]} + {1'b0, cnt_q};
  assign span_ok  = ~span_sum[LINE_W];

  generate
    if (DATA_W > LINE_W) begin : g_wide
      assign cnt_ok = ~|data[DATA_W-1:LINE_W];
    end else begin : g_narrow
      assign cnt_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/nwb_buf.sv
module nwb_buf #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nwb_fsm.sv
module nwb_fsm
  import nwb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  parameter int LINE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          data,
  input  logic                       sec_ok,
  input  logic                       line_ok,
  input  logic                       span_ok,
  input  logic                       cnt_ok,
  output logic [ADDR_W-SECT_LSB-1:0] sect_q,
  output logic [ADDR_W-LINE_W-1:0]   line_q,
  output logic [LINE_W-1:0]          cnt_q,
  output logic                       store,
  output logic                       busy,
  output logic                       abort_flag,
  output logic                       go_pulse,
  output logic [ADDR_W-LINE_W-1:0]   go_line,
  output logic [LINE_W-1:0]          go_first,
  output logic [LINE_W-1:0]          go_count
);
  nwb_st_e st_q, st_d;
  logic [LINE_W-1:0] rem_q, first_q;
  logic key1, key2, is_load, is_conf, is_clear, go_now;

  assign key1     = addr[11:0] == AD_KEY1 && data == DATA_W'(OP_KEY1);
  assign key2     = addr[11:0] == AD_KEY2 && data == DATA_W'(OP_KEY2);
  assign is_load  = data == DATA_W'(OP_LOAD);
  assign is_conf  = data == DATA_W'(OP_CONF);
  assign is_clear = data == DATA_W'(OP_CLEAR);

  always_comb begin
    st_d   = st_q;
    store  = 1'b0;
    go_now = 1'b0;
    if (we) begin
      unique case (st_q)
        S_IDLE: if (key1) st_d = S_UN1;
        S_UN1:  st_d = key2 ? S_UN2 : S_IDLE;
        S_UN2:  st_d = is_load ? S_CNT : S_IDLE;
        S_CNT:  st_d = (sec_ok && cnt_ok) ? S_LD0 : S_AB;
        S_LD0: begin
          if (sec_ok && span_ok) begin
            store = 1'b1;
            st_d  = (rem_q == '0) ? S_CONF : S_LDN;
          end else st_d = S_AB;
        end
        S_LDN: begin
          if (sec_ok && line_ok) begin
            store = 1'b1;
            st_d  = (rem_q == '0) ? S_CONF : S_LDN;
          end else st_d = S_AB;
        end
        S_CONF: begin
          if (sec_ok && is_conf) begin
            go_now = 1'b1;
            st_d   = S_IDLE;
          end else st_d = S_AB;
        end
        S_AB:  if (key1) st_d = S_AB1;
        S_AB1: st_d = key2 ? S_AB2 : S_AB;
        S_AB2: st_d = is_clear ? S_IDLE : S_AB;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      sect_q     <= '0;
      line_q     <= '0;
      cnt_q      <= '0;
      rem_q      <= '0;
      first_q    <= '0;
      busy       <= 1'b0;
      abort_flag <= 1'b0;
      go_pulse   <= 1'b0;
      go_line    <= '0;
      go_first   <= '0;
      go_count   <= '0;
    end else begin
      st_q       <= st_d;
      busy       <= !(st_d inside {S_IDLE, S_UN1, S_UN2});
      abort_flag <= st_d inside {S_AB, S_AB1, S_AB2};
      go_pulse   <= go_now;
      if (we && st_q == S_UN2 && is_load) sect_q <= addr[ADDR_W-1:SECT_LSB];
      if (we && st_q == S_CNT) begin
        cnt_q <= data[LINE_W-1:0];
        rem_q <= data[LINE_W-1:0];
      end
      if (store) begin
        rem_q <= rem_q - 1'b1;
        if (st_q == S_LD0) begin
          line_q  <= addr[ADDR_W-1:LINE_W];
          first_q <= addr[LINE_W-1:0];
        end
      end
      if (go_now) begin
        go_line  <= line_q;
        go_first <= first_q;
        go_count <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/nor_wbuf_seq.sv
module nor_wbuf_seq #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  parameter int LINE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_data,
  output logic                     busy,
  output logic                     abort_flag,
  output logic                     go_pulse,
  output logic [ADDR_W-LINE_W-1:0] go_line,
  output logic [LINE_W-1:0]        go_first,
  output logic [LINE_W-1:0]        go_count,
  input  logic [LINE_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]        rd_word
);
  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int LN_W   = ADDR_W - LINE_W;

  logic [SECT_W-1:0] sect_q;
  logic [LN_W-1:0]   line_q;
  logic [LINE_W-1:0] cnt_q;
  logic sec_ok, line_ok, span_ok, cnt_ok, store;

  nwb_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .LINE_W(LINE_W)) u_guard (
    .addr(bus_addr), .data(bus_data), .sect_q(sect_q), .line_q(line_q), .cnt_q(cnt_q),
    .sec_ok(sec_ok), .line_ok(line_ok), .span_ok(span_ok), .cnt_ok(cnt_ok)
  );

  nwb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .LINE_W(LINE_W)) u_fsm (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .data(bus_data),
    .sec_ok(sec_ok), .line_ok(line_ok), .span_ok(span_ok), .cnt_ok(cnt_ok),
    .sect_q(sect_q), .line_q(line_q), .cnt_q(cnt_q), .store(store),
    .busy(busy), .abort_flag(abort_flag), .go_pulse(go_pulse),
    .go_line(go_line), .go_first(go_first), .go_count(go_count)
  );

  nwb_buf #(.IDX_W(LINE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .we(store), .waddr(bus_addr[LINE_W-1:0]), .wdata(bus_data),
    .raddr(rd_idx), .rdata(rd_word)
  );
endmodule

// File: rtl/nwb_chk.sv
module nwb_chk (
  input logic clk,
  input logic rst,
  input logic bus_we,
  input logic busy,
  input logic abort_flag,
  input logic go_pulse
);
  a_r8_go_single: assert property (@(posedge clk) disable iff (rst) go_pulse |=> !go_pulse);
  a_r8_go_idle: assert property (@(posedge clk) disable iff (rst) go_pulse |-> !busy && !abort_flag);
  a_r8_go_after_load: assert property (@(posedge clk) disable iff (rst) $rose(go_pulse) |-> $past(busy));
  a_r9_abort_busy: assert property (@(posedge clk) disable iff (rst) abort_flag |-> busy);
  a_r9_abort_from_load: assert property (@(posedge clk) disable iff (rst) $rose(abort_flag) |-> $past(busy));
  a_r9_clear_needs_write: assert property (@(posedge clk) disable iff (rst) $fell(abort_flag) |-> $past(bus_we));
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we) |-> $stable(busy) && $stable(abort_flag));
endmodule

bind nor_wbuf_seq nwb_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .busy(busy),
  .abort_flag(abort_flag), .go_pulse(go_pulse)
);

// File: tb/nor_wbuf_seq_test.sv
`timescale 1ns/1ps
module nor_wbuf_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_data = '0;
  logic busy, abort_flag, go_pulse;
  logic [7:0] go_line, go_first, go_count;
  logic [7:0] rd_idx = '0;
  logic [15:0] rd_word;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nor_wbuf_seq uut (.*);

  // {req[3:0], addr[15:0], data[15:0], busy, abort, go}
  localparam int N = 55;
  localparam logic [38:0] TBL [N] = '{
    // R1 R3 R4 R5 R8: three-word load then confirm
    {4'd1,16'h0555,16'h00AA,3'b000}, {4'd1,16'h02AA,16'h0055,3'b000},
    {4'd3,16'h3000,16'h0025,3'b100}, {4'd4,16'h3000,16'h0002,3'b100},
    {4'd5,16'h3110,16'h1111,3'b100}, {4'd5,16'h3111,16'h2222,3'b100},
    {4'd5,16'h3112,16'h3333,3'b100}, {4'd8,16'h3000,16'h0029,3'b001},
    // R2 bad second key, R1 bare opcode
    {4'd2,16'h0555,16'h00AA,3'b000}, {4'd2,16'h02AA,16'h0077,3'b000},
    {4'd1,16'h3000,16'h0025,3'b000},
    // R6 sector mismatch, R9 sticky
    {4'd1,16'h0555,16'h00AA,3'b000}, {4'd1,16'h02AA,16'h0055,3'b000},
    {4'd3,16'h3000,16'h0025,3'b100}, {4'd4,16'h3000,16'h0001,3'b100},
    {4'd6,16'h4010,16'hABCD,3'b110}, {4'd9,16'h3000,16'h0029,3'b110},
    {4'd9,16'h0555,16'h00AA,3'b110}, {4'd9,16'h02AA,16'h0055,3'b110},
    {4'd9,16'h0000,16'h00F0,3'b000},
    // R4 count too large
    {4'd1,16'h0555,16'h00AA,3'b000}, {4'd1,16'h02AA,16'h0055,3'b000},
    {4'd3,16'h3000,16'h0025,3'b100}, {4'd4,16'h3000,16'h0100,3'b110},
    {4'd9,16'h0555,16'h00AA,3'b110}, {4'd9,16'h02AA,16'h0055,3'b110},
    {4'd9,16'h0000,16'h00F0,3'b000},
    // R7 span past line end
    {4'd1,16'h0555,16'h00AA,3'b000}, {4'd1,16'h02AA,16'h0055,3'b000},
    {4'd3,16'h5000,16'h0025,3'b100}, {4'd4,16'h5000,16'h0003,3'b100},
    {4'd7,16'h50FE,16'h1234,3'b110}, {4'd9,16'h0555,16'h00AA,3'b110},
    {4'd9,16'h02AA,16'h0055,3'b110}, {4'd9,16'h0000,16'h00F0,3'b000},
    // R8 wrong confirm
    {4'd1,16'h0555,16'h00AA,3'b000}, {4'd1,16'h02AA,16'h0055,3'b000},
    {4'd3,16'h3000,16'h0025,3'b100}, {4'd4,16'h3000,16'h0000,3'b100},
    {4'd5,16'h3020,16'h5555,3'b100}, {4'd8,16'h3000,16'h0030,3'b110},
    {4'd9,16'h0555,16'h00AA,3'b110}, {4'd9,16'h02AA,16'h0055,3'b110},
    {4'd9,16'h0000,16'h00F0,3'b000},
    // R7 line change, R9 broken clear keeps abort
    {4'd1,16'h0555,16'h00AA,3'b000}, {4'd1,16'h02AA,16'h0055,3'b000},
    {4'd3,16'h3000,16'h0025,3'b100}, {4'd4,16'h3000,16'h0001,3'b100},
    {4'd5,16'h3120,16'h0001,3'b100}, {4'd7,16'h3220,16'h0002,3'b110},
    {4'd9,16'h0555,16'h00AA,3'b110}, {4'd9,16'h02AA,16'h0066,3'b110},
    {4'd9,16'h0555,16'h00AA,3'b110}, {4'd9,16'h02AA,16'h0055,3'b110},
    {4'd9,16'h0000,16'h00F0,3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, input logic [15:0] exp);
    @(negedge clk); rd_idx = i;
    @(negedge clk);
    chk("R5 readback", {16'h0, rd_word}, {16'h0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R10: writes while reset is held are ignored
    repeat (2) @(negedge clk);
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
    @(negedge clk); rst = 1'b0;
    chk("R10 reset state", {29'h0, busy, abort_flag, go_pulse}, 32'h0);
    wr(16'h3000, 16'h0025);
    chk("R10 unlock during reset ignored", {31'h0, busy}, 32'h0);

    for (int i = 0; i < N; i++) begin
      wr(TBL[i][34:19], TBL[i][18:3]);
      chk($sformatf("R%0d table[%0d]", TBL[i][38:35], i),
          {29'h0, busy, abort_flag, go_pulse}, {29'h0, TBL[i][2:0]});
      if (TBL[i][0]) begin
        chk("R8 go_line", {24'h0, go_line}, 32'h31);
        chk("R8 go_first", {24'h0, go_first}, 32'h10);
        chk("R8 go_count", {24'h0, go_count}, 32'h02);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'h0, go_pulse}, 32'h0);
      end
    end

    // R5: words of the first load, untouched by the aborted ones
    rd(8'h10, 16'h1111);
    rd(8'h11, 16'h2222);
    rd(8'h12, 16'h3333);

    // R4 boundary: full 256-word line with count 00FFh
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
    wr(16'h6000, 16'h0025);
    wr(16'h6000, 16'h00FF);
    for (int k = 0; k < 256; k++) wr(16'h6000 + 16'(k), 16'(k) ^ 16'hA5A5);
    chk("R4 full line still loading", {30'h0, busy, abort_flag}, 32'h2);
    wr(16'h6000, 16'h0029);
    chk("R8 full line go", {29'h0, busy, abort_flag, go_pulse}, 32'h1);
    chk("R4 full count", {24'h0, go_count}, 32'hFF);
    chk("R8 full line addr", {16'h0, go_line, go_first}, 32'h6000);
    rd(8'h00, 16'hA5A5);
    rd(8'hFF, 16'hA55A);

    finish_run();
  end
endmodule